// File: doc/BRIEF.md
# Dual-Channel Phase Comparator with Lock Monitor

This block holds two identical phase comparators, one per synthesizer loop. Each one takes a reference pulse train and a divided feedback pulse train, both sampled in the oscillator clock domain. It finds out which edge came first and drives a charge-pump command for as long as the other edge is still missing. The command is encoded on two wires. A polarity input swaps the two drive directions so that either sense of oscillator tuning can be served. Each channel also times every error window in oscillator cycles and keeps a lock flag with hysteresis: the flag falls early on a wide error, and it rises again only after a run of narrow ones.

A power-save input per channel puts the pump command into high impedance. While asleep, the channel reports itself as locked and forgets both its phase state and its lock history. The first error window after waking is limited in length, so that the undefined phase relation at wake-up cannot produce one large correction.

A single monitor output is registered. It carries either the AND of the two channel lock flags, or one of the four raw pulse inputs picked by a two-bit tap code.

Top module: `pfdl_dual_top`

## Requirements
- R1: Pump encoding: `pump_up`=1 means drive high, `pump_dn`=1 means drive low, both 0 means high impedance, and both 1 means the anti-dead-zone pulse. With `pol_fwd`=1, a reference edge that leads the feedback edge by w cycles gives exactly w cycles of `pump_up` alone, and a feedback edge that leads gives w cycles of `pump_dn` alone. Once the comparison has ended and its pulse has passed, both outputs return to 0.
- R2: With `pol_fwd`=0, the two drive directions of R1 are exchanged. Equal edges still give no drive window.
- R3: Every completed comparison, including one with simultaneous edges, is followed by exactly one cycle with both pump outputs at 1.
- R4: Further reference edges that arrive while the comparator is still waiting for a feedback edge do not end or restart the error window, and the same holds with the roles of the two inputs swapped.
- R5: Once an error window reaches UNLOCK_W cycles (default 8), the channel lock flag drops one cycle later, while the window is still open.
- R6: A completed window of at most LOCK_W cycles (default 3) counts as good. The lock flag rises only after GOOD_N (default 3) good windows in a row. A window strictly between LOCK_W and UNLOCK_W clears the run and leaves the flag unchanged.
- R7: While `sleep` is high, both pump outputs of that channel are 0 in the same cycle and `chan_lock` reads 1. After wake-up, the lock flag is 0 until a fresh run of good windows has been seen.
- R8: In the first comparison after wake-up, the drive window lasts at most FIRST_CAP cycles (default 2). Its width is still measured for the lock flag.
- R9: With `mon_sel`=0, `mon_out` equals the AND of both `chan_lock` bits, registered one cycle.
- R10: With `mon_sel`=1, `mon_out` gives the raw input picked by `tap_sel`, registered one cycle. Bit 0 of `tap_sel` picks the channel (0 or 1), and bit 1 picks feedback (1) or reference (0).
- R11: After reset, all pump outputs, both lock flags (with `sleep` low) and `mon_out` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_pls | input | NCH | Reference pulse per channel |
| div_pls | input | NCH | Divided feedback pulse per channel |
| pol_fwd | input | NCH | Pump polarity per channel |
| sleep | input | NCH | Power-save per channel |
| mon_sel | input | 1 | Monitor source: 0 lock, 1 tap |
| tap_sel | input | 2 | Tap code for the monitor |
| pump_up | output | NCH | Drive-high command |
| pump_dn | output | NCH | Drive-low command |
| chan_lock | output | NCH | Per-channel lock flag |
| mon_out | output | 1 | Registered monitor output |

## Verification
The assertions assume that the pulse inputs are synchronous to `clk`, that they change only between edges, and that the comparator acts only on their rising edges. They also assume the threshold parameters keep LOCK_W below UNLOCK_W and UNLOCK_W at two or more. The stimulus drives every input on the falling edge, keeps each pulse high for one cycle, and always closes an open window with the partner edge, except when a channel is put to sleep on purpose. Offsets from −9 to +9 cycles are swept for both polarities on both channels, so the widths cross both thresholds in each direction.

// File: rtl/pfdl_pkg.sv
package pfdl_pkg;
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_LEAD = 2'd1,
    PH_LAG  = 2'd2
  } ph_state_t;
endpackage

// File: rtl/pfdl_phase.sv
module pfdl_phase
  import pfdl_pkg::*;
#(
  parameter int UNLOCK_W  = 8,
  parameter int FIRST_CAP = 2,
  localparam int CW = $clog2(UNLOCK_W + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sleep_i,
  input  logic          pol_i,
  input  logic          ref_i,
  input  logic          div_i,
  output logic          up_o,
  output logic          dn_o,
  output logic          done_o,
  output logic [CW-1:0] width_o,
  output logic          over_o
);

  ph_state_t   st_q, st_n;
  logic [CW-1:0] cnt_q, cnt_n, cnt_inc;
  logic [CW-1:0] width_q, width_n;
  logic        ref_d_q, div_d_q;
  logic        ref_evt, div_evt;
  logic        done_q, done_n;
  logic        over_q, over_n;
  logic        blip_q, blip_n;
  logic        first_q, first_n;
  logic        capped, raw_up, raw_dn;

  assign ref_evt = ref_i & ~ref_d_q;
  assign div_evt = div_i & ~div_d_q;
  assign cnt_inc = (cnt_q == CW'(UNLOCK_W)) ? cnt_q : cnt_q + CW'(1);

  // next-state logic
  always_comb begin
    st_n    = st_q;
    cnt_n   = cnt_q;
    width_n = width_q;
    done_n  = 1'b0;
    blip_n  = 1'b0;
    first_n = first_q;
    unique case (st_q)
      PH_IDLE: begin
        if (ref_evt && div_evt) begin
          done_n  = 1'b1;
          blip_n  = 1'b1;
          width_n = '0;
        end else if (ref_evt) begin
          st_n  = PH_LEAD;
          cnt_n = CW'(1);
        end else if (div_evt) begin
          st_n  = PH_LAG;
          cnt_n = CW'(1);
        end
      end
      PH_LEAD: begin
        if (div_evt) begin
          done_n  = 1'b1;
          blip_n  = 1'b1;
          width_n = cnt_q;
          st_n    = ref_evt ? PH_LEAD : PH_IDLE;
          cnt_n   = ref_evt ? CW'(1) : '0;
        end else begin
          cnt_n = cnt_inc;
        end
      end
      PH_LAG: begin
        if (ref_evt) begin
          done_n  = 1'b1;
          blip_n  = 1'b1;
          width_n = cnt_q;
          st_n    = div_evt ? PH_LAG : PH_IDLE;
          cnt_n   = div_evt ? CW'(1) : '0;
        end else begin
          cnt_n = cnt_inc;
        end
      end
      default: begin
        st_n  = PH_IDLE;
        cnt_n = '0;
      end
    endcase
    over_n = (cnt_n == CW'(UNLOCK_W)) && (cnt_q != CW'(UNLOCK_W));
    if (done_n) first_n = 1'b0;
    if (sleep_i) begin
      st_n    = PH_IDLE;
      cnt_n   = '0;
      done_n  = 1'b0;
      blip_n  = 1'b0;
      over_n  = 1'b0;
      first_n = 1'b1;
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= PH_IDLE;
      cnt_q   <= '0;
      width_q <= '0;
      ref_d_q <= 1'b0;
      div_d_q <= 1'b0;
      done_q  <= 1'b0;
      over_q  <= 1'b0;
      blip_q  <= 1'b0;
      first_q <= 1'b0;
    end else begin
      st_q    <= st_n;
      cnt_q   <= cnt_n;
      ref_d_q <= ref_i;
      div_d_q <= div_i;
      done_q  <= done_n;
      over_q  <= over_n;
      blip_q  <= blip_n;
      first_q <= first_n;
      if (done_n) width_q <= width_n;
    end
  end

  // output decode: window limited on the first comparison after wake
  assign capped = first_q && (int'(cnt_q) > FIRST_CAP);
  assign raw_up = ((st_q == PH_LEAD) && !capped) || blip_q;
  assign raw_dn = ((st_q == PH_LAG)  && !capped) || blip_q;
  assign up_o   = !sleep_i && (pol_i ? raw_up : raw_dn);
  assign dn_o   = !sleep_i && (pol_i ? raw_dn : raw_up);

  assign done_o  = done_q;
  assign width_o = width_q;
  assign over_o  = over_q;

  // R5: measured width never exceeds the saturation point
  a_r5_width_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> (int'(width_q) <= UNLOCK_W));

  // R7: sleeping clears the comparator
  a_r7_sleep_clears: assert property (@(posedge clk) disable iff (!rst_n)
    sleep_i |=> (st_q == PH_IDLE && cnt_q == '0 && !blip_q));

endmodule

// File: rtl/pfdl_lockdet.sv
module pfdl_lockdet #(
  parameter int UNLOCK_W = 8,
  parameter int LOCK_W   = 3,
  parameter int GOOD_N   = 3,
  parameter int CW       = 4,
  localparam int SW      = $clog2(GOOD_N + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sleep_i,
  input  logic          done_i,
  input  logic [CW-1:0] width_i,
  input  logic          over_i,
  output logic          lock_o
);

  logic          lock_q, lock_n;
  logic [SW-1:0] streak_q, streak_n;

  always_comb begin
    lock_n   = lock_q;
    streak_n = streak_q;
    if (sleep_i || over_i) begin
      lock_n   = 1'b0;
      streak_n = '0;
    end else if (done_i) begin
      if (int'(width_i) >= UNLOCK_W) begin
        lock_n   = 1'b0;
        streak_n = '0;
      end else if (int'(width_i) <= LOCK_W) begin
        if (streak_q != SW'(GOOD_N)) streak_n = streak_q + SW'(1);
        if (streak_n == SW'(GOOD_N)) lock_n = 1'b1;
      end else begin
        streak_n = '0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lock_q   <= 1'b0;
      streak_q <= '0;
    end else begin
      lock_q   <= lock_n;
      streak_q <= streak_n;
    end
  end

  assign lock_o = sleep_i || lock_q;

  // R5: a window reaching the unlock width drops the flag
  a_r5_over_drops: assert property (@(posedge clk) disable iff (!rst_n)
    (over_i && !sleep_i) |=> !lock_q);

  // R6: the flag only rises on a completed comparison
  a_r6_rise_on_done: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lock_q) |-> $past(done_i && !sleep_i));

endmodule

// File: rtl/pfdl_monmux.sv
module pfdl_monmux #(
  parameter int NCH = 2,
  localparam int SELW = 1 + $clog2(NCH)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            mon_sel_i,
  input  logic [SELW-1:0] tap_sel_i,
  input  logic [NCH-1:0]  ref_i,
  input  logic [NCH-1:0]  div_i,
  input  logic            lock_all_i,
  output logic            mon_o
);

  logic [SELW-2:0] chan_idx;
  logic [NCH-1:0]  src;
  logic            tap_sig;
  logic            mon_q, mon_n;

  assign chan_idx = tap_sel_i[SELW-2:0];
  assign src      = tap_sel_i[SELW-1] ? div_i : ref_i;

  always_comb begin
    tap_sig = 1'b0;
    if (int'(chan_idx) < NCH) tap_sig = src[chan_idx];
    mon_n = mon_sel_i ? tap_sig : lock_all_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mon_q <= 1'b0;
    else        mon_q <= mon_n;
  end

  assign mon_o = mon_q;

  // R10: tap 0 follows the first reference input one cycle later
  a_r10_tap_ref0: assert property (@(posedge clk) disable iff (!rst_n)
    (mon_sel_i && tap_sel_i == '0) |=> (mon_q == $past(ref_i[0])));

endmodule

// File: rtl/pfdl_dual_top.sv
module pfdl_dual_top #(
  parameter int NCH       = 2,
  parameter int UNLOCK_W  = 8,
  parameter int LOCK_W    = 3,
  parameter int GOOD_N    = 3,
  parameter int FIRST_CAP = 2,
  localparam int SELW     = 1 + $clog2(NCH),
  localparam int CW       = $clog2(UNLOCK_W + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NCH-1:0]  ref_pls,
  input  logic [NCH-1:0]  div_pls,
  input  logic [NCH-1:0]  pol_fwd,
  input  logic [NCH-1:0]  sleep,
  input  logic            mon_sel,
  input  logic [SELW-1:0] tap_sel,
  output logic [NCH-1:0]  pump_up,
  output logic [NCH-1:0]  pump_dn,
  output logic [NCH-1:0]  chan_lock,
  output logic            mon_out
);

  logic rst_meta, rst_sync_n;
  logic lock_all;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta   <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta   <= 1'b1;
      rst_sync_n <= rst_meta;
    end
  end

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic          done_w, over_w;
    logic [CW-1:0] width_w;

    pfdl_phase #(
      .UNLOCK_W (UNLOCK_W),
      .FIRST_CAP(FIRST_CAP)
    ) i_phase (
      .clk    (clk),
      .rst_n  (rst_sync_n),
      .sleep_i(sleep[c]),
      .pol_i  (pol_fwd[c]),
      .ref_i  (ref_pls[c]),
      .div_i  (div_pls[c]),
      .up_o   (pump_up[c]),
      .dn_o   (pump_dn[c]),
      .done_o (done_w),
      .width_o(width_w),
      .over_o (over_w)
    );

    pfdl_lockdet #(
      .UNLOCK_W(UNLOCK_W),
      .LOCK_W  (LOCK_W),
      .GOOD_N  (GOOD_N),
      .CW      (CW)
    ) i_lockdet (
      .clk    (clk),
      .rst_n  (rst_sync_n),
      .sleep_i(sleep[c]),
      .done_i (done_w),
      .width_i(width_w),
      .over_i (over_w),
      .lock_o (chan_lock[c])
    );
  end

  assign lock_all = &chan_lock;

  pfdl_monmux #(.NCH(NCH)) i_monmux (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .mon_sel_i (mon_sel),
    .tap_sel_i (tap_sel),
    .ref_i     (ref_pls),
    .div_i     (div_pls),
    .lock_all_i(lock_all),
    .mon_o     (mon_out)
  );

  // R9: lock monitor carries the AND of the channel flags
  a_r9_mon_lock: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!mon_sel) |=> (mon_out == $past(&chan_lock)));

  // R7: a sleeping channel never drives its pump
  a_r7_sleep_quiet: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (sleep[0] |-> (!pump_up[0] && !pump_dn[0])));

endmodule

// File: tb/test_pfdl_dual_top.sv
module test_pfdl_dual_top;
  localparam int UNL = 8;
  localparam int LKW = 3;
  localparam int GDN = 3;
  localparam int CAP = 2;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [1:0] ref_pls, div_pls, pol_fwd, sleep, tap_sel;
  logic       mon_sel;
  logic [1:0] pump_up, pump_dn, chan_lock;
  logic       mon_out;

  int n_chk = 0;
  int n_fail = 0;
  bit fin = 1'b0;
  int lk[2];
  int stk[2];

  always #2 clk = ~clk;

  pfdl_dual_top #(.NCH(2), .UNLOCK_W(UNL), .LOCK_W(LKW), .GOOD_N(GDN),
                  .FIRST_CAP(CAP)) i_pfdl_dual_top (
    .clk(clk), .rst_n(rst_n), .ref_pls(ref_pls), .div_pls(div_pls),
    .pol_fwd(pol_fwd), .sleep(sleep), .mon_sel(mon_sel), .tap_sel(tap_sel),
    .pump_up(pump_up), .pump_dn(pump_dn), .chan_lock(chan_lock),
    .mon_out(mon_out)
  );

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_done(int ch, int w);
    if (w >= UNL) begin
      lk[ch] = 0; stk[ch] = 0;
    end else if (w <= LKW) begin
      if (stk[ch] < GDN) stk[ch]++;
      if (stk[ch] == GDN) lk[ch] = 1;
    end else begin
      stk[ch] = 0;
    end
  endtask

  // d > 0: reference leads by d cycles; d < 0: feedback leads; 0: together
  task automatic run_cmp(int ch, int d, bit pl, int cap);
    int  w;
    bit  lead;
    bit  on;
    int  prev;
    w = (d < 0) ? -d : d;
    lead = (d > 0);
    prev = lk[ch];
    @(negedge clk);
    pol_fwd[ch] = pl;
    @(negedge clk);
    if (d >= 0) ref_pls[ch] = 1'b1;
    if (d <= 0) div_pls[ch] = 1'b1;
    for (int i = 1; i <= w; i++) begin
      @(negedge clk);
      ref_pls[ch] = 1'b0;
      div_pls[ch] = 1'b0;
      on = (cap == 0) || (i <= cap);
      chk(cap != 0 ? "R8 up" : (pl ? "R1 up" : "R2 up"),
          int'(pump_up[ch]), int'(on && (pl == lead)));
      chk(cap != 0 ? "R8 dn" : (pl ? "R1 dn" : "R2 dn"),
          int'(pump_dn[ch]), int'(on && (pl != lead)));
      if (w > UNL && i == UNL) chk("R5 held before drop", int'(chan_lock[ch]), prev);
      if (w > UNL && i == UNL + 1) chk("R5 early drop", int'(chan_lock[ch]), 0);
      if (i == w) begin
        if (lead) div_pls[ch] = 1'b1;
        else      ref_pls[ch] = 1'b1;
      end
    end
    @(negedge clk);
    ref_pls[ch] = 1'b0;
    div_pls[ch] = 1'b0;
    chk("R3 pulse", int'({pump_up[ch], pump_dn[ch]}), 3);
    @(negedge clk);
    chk("R1 idle z", int'({pump_up[ch], pump_dn[ch]}), 0);
    model_done(ch, (w > UNL) ? UNL : w);
    chk("R6 lock flag", int'(chan_lock[ch]), lk[ch]);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!fin) begin
      n_fail++;
      $display("FAIL watchdog: actual 0 expected 1 (run did not finish)");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    ref_pls = '0; div_pls = '0; pol_fwd = '0; sleep = '0;
    tap_sel = '0; mon_sel = 1'b0;
    lk[0] = 0; lk[1] = 0; stk[0] = 0; stk[1] = 0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk("R11 pump_up", int'(pump_up), 0);
    chk("R11 pump_dn", int'(pump_dn), 0);
    chk("R11 chan_lock", int'(chan_lock), 0);
    chk("R11 mon_out", int'(mon_out), 0);

    // offset sweep for both channels and polarities
    for (int ch = 0; ch < 2; ch++)
      for (int p = 0; p < 2; p++)
        for (int d = -9; d <= 9; d++)
          run_cmp(ch, d, p[0], 0);

    // early drop on a long window after lock
    for (int k = 0; k < 3; k++) run_cmp(0, 1, 1'b1, 0);
    chk("R6 locked", int'(chan_lock[0]), 1);
    run_cmp(0, 12, 1'b1, 0);
    for (int k = 0; k < 3; k++) run_cmp(0, -2, 1'b0, 0);
    chk("R6 relocked", int'(chan_lock[0]), 1);
    run_cmp(0, 5, 1'b1, 0);
    chk("R6 middle width holds flag", int'(chan_lock[0]), 1);
    run_cmp(0, 1, 1'b1, 0);
    run_cmp(0, 1, 1'b1, 0);
    chk("R6 streak restarted", int'(chan_lock[0]), 1);

    // R4: second reference edge inside an open window
    @(negedge clk); pol_fwd[0] = 1'b1;
    @(negedge clk); ref_pls[0] = 1'b1;
    @(negedge clk); ref_pls[0] = 1'b0; chk("R4 up c1", int'(pump_up[0]), 1);
    @(negedge clk); ref_pls[0] = 1'b1; chk("R4 up c2", int'(pump_up[0]), 1);
    @(negedge clk); ref_pls[0] = 1'b0; chk("R4 up c3", int'(pump_up[0]), 1);
    @(negedge clk); chk("R4 up c4", int'(pump_up[0]), 1);
    @(negedge clk); chk("R4 up c5", int'(pump_up[0]), 1);
    chk("R4 no dn", int'(pump_dn[0]), 0);
    div_pls[0] = 1'b1;
    @(negedge clk); div_pls[0] = 1'b0;
    chk("R4 pulse", int'({pump_up[0], pump_dn[0]}), 3);
    @(negedge clk); chk("R4 idle", int'({pump_up[0], pump_dn[0]}), 0);
    model_done(0, 5);

    // R7 and R8: sleep in an open window, wake, capped first window
    for (int k = 0; k < 3; k++) run_cmp(0, 0, 1'b1, 0);
    chk("R7 locked before sleep", int'(chan_lock[0]), 1);
    @(negedge clk); ref_pls[0] = 1'b1;
    @(negedge clk); ref_pls[0] = 1'b0; chk("R7 open window", int'(pump_up[0]), 1);
    @(negedge clk); sleep[0] = 1'b1;
    #1;
    chk("R7 pump quiet", int'({pump_up[0], pump_dn[0]}), 0);
    chk("R7 reports lock", int'(chan_lock[0]), 1);
    repeat (3) @(negedge clk);
    chk("R7 still quiet", int'({pump_up[0], pump_dn[0]}), 0);
    sleep[0] = 1'b0;
    lk[0] = 0; stk[0] = 0;
    @(negedge clk); @(negedge clk);
    chk("R7 history cleared", int'(chan_lock[0]), 0);
    chk("R7 idle after wake", int'({pump_up[0], pump_dn[0]}), 0);
    run_cmp(0, 6, 1'b1, CAP);
    run_cmp(0, 5, 1'b1, 0);

    // R9: combined lock on the monitor
    for (int k = 0; k < 3; k++) run_cmp(0, 1, 1'b1, 0);
    for (int k = 0; k < 3; k++) run_cmp(1, -1, 1'b1, 0);
    @(negedge clk);
    chk("R9 both locked", int'(mon_out), 1);
    run_cmp(1, 9, 1'b1, 0);
    @(negedge clk);
    chk("R9 one unlocked", int'(mon_out), 0);
    sleep[1] = 1'b1;
    @(negedge clk);
    chk("R9 sleep counts locked", int'(mon_out), 1);
    sleep[0] = 1'b1;
    @(negedge clk);
    chk("R9 both asleep", int'(mon_out), 1);

    // R10: tap sweep over every source
    mon_sel = 1'b1;
    for (int t = 0; t < 4; t++)
      for (int s = 0; s < 4; s++) begin
        @(negedge clk);
        tap_sel = t[1:0];
        if (s[1]) div_pls[s[0]] = 1'b1;
        else      ref_pls[s[0]] = 1'b1;
        @(negedge clk);
        chk("R10 tap", int'(mon_out), int'(t == s));
        ref_pls = '0;
        div_pls = '0;
        @(negedge clk);
        chk("R10 tap low", int'(mon_out), 0);
      end
    mon_sel = 1'b0;
    @(negedge clk); @(negedge clk);
    chk("R9 back to lock", int'(mon_out), 1);

    fin = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule